// File: doc/BRIEF.md
# Serial Line Transmit Register Pair

This block is the transmit half of one line of a bus-mapped terminal interface. It holds a 16-bit transmit control/status word and an 8-bit character buffer. A processor reaches both over a simple word bus that has byte-lane information. It then passes each character to a UART transmitter through a valid/ready handshake.

Software writes a character into the buffer, and the write starts a transfer. While the character waits for the serializer, the done flag stays clear. Done rises in the cycle after the transmitter accepts the character. If interrupts are enabled, a transmit interrupt request rises with it.

The maintenance-loopback and transmit-break controls are stored bits that software can read back. They drive nothing inside this block.

Top module: `serial_tx_regs`

## Requirements
- R1: After synchronous reset, the status word reads 0x0080 (done set, all other bits clear), the buffer reads 0x0000, `tx_valid` is low and `tx_irq` is low.
- R2: An even-byte status write (`bus_sel`=0, `bus_odd`=0) updates interrupt enable (bit 6), maintenance (bit 2) and break (bit 0) from `bus_wdata`. Done (bit 7) is read-only, and all other status bits read as zero.
- R3: A status write with `bus_odd`=1 changes no status bit and does not change `tx_irq`.
- R4: An even-byte buffer write (`bus_sel`=1, `bus_odd`=0) loads `bus_wdata[7:0]`. The buffer then reads as that byte zero-extended to 16 bits, and `tx_data` presents it.
- R5: Any buffer write, even or odd byte, clears done, drops `tx_irq` and raises `tx_valid` in the next cycle. An odd-byte buffer write leaves the stored byte unchanged.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and done stays clear, for as many cycles as the line stalls.
- R7: In the cycle after a handshake (`tx_valid` and `tx_ready` both high), `tx_valid` is low and done is set. Each buffer write yields exactly one handshake.
- R8: When a character completes with interrupt enable set, `tx_irq` rises in the same cycle as done.
- R9: Writing interrupt enable as 0 drops `tx_irq` in the next cycle. Writing it as 1 while done is set raises `tx_irq` in the next cycle.
- R10: If a buffer write lands in the same cycle as a handshake, the new transfer wins. Done stays clear, `tx_valid` stays high, and the newly written byte is sent next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_sel | input | 1 | Register select: 0 status word, 1 character buffer |
| bus_odd | input | 1 | Byte lane: 1 addresses the odd (upper) byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| tx_data | output | 8 | Character offered to the transmitter |
| tx_valid | output | 1 | Character waiting for the transmitter |
| tx_ready | input | 1 | Transmitter accepts the character |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The hardest case to reach is a buffer write that arrives in exactly the cycle the transmitter accepts the previous character. In that case a completion and a new start compete for the done flag. The bench reaches it by holding `tx_ready` low until a first character is pending. It then raises `tx_ready` on the same falling edge that drives the second buffer write. After that, it checks the flags, the presented byte and the running handshake count. Stalls of several cycles with `tx_ready` low cover the wait-and-retry path.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    localparam int WORD_W  = 16;
    localparam int CHAR_W  = 8;
    localparam int DONE_B  = 7;
    localparam int IE_B    = 6;
    localparam int MAINT_B = 2;
    localparam int BRK_B   = 0;

    typedef struct packed {
        logic done;
        logic ie;
        logic maint;
        logic brk;
    } tx_status_t;

    typedef struct packed {
        logic status_wr;
        logic buf_start;
        logic buf_load;
    } tx_op_t;

    localparam tx_status_t STATUS_RESET = '{done: 1'b1, ie: 1'b0, maint: 1'b0, brk: 1'b0};

    function automatic logic [WORD_W-1:0] pack_status(input tx_status_t s);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[DONE_B]  = s.done;
        w[IE_B]    = s.ie;
        w[MAINT_B] = s.maint;
        w[BRK_B]   = s.brk;
        return w;
    endfunction

endpackage

// File: rtl/serial_tx_decode.sv
module serial_tx_decode
    import serial_tx_pkg::*;
(
    input  logic   bus_wr,
    input  logic   bus_sel,
    input  logic   bus_odd,
    output tx_op_t op
);
    always_comb begin
        op           = '0;
        op.status_wr = bus_wr && !bus_sel && !bus_odd;
        op.buf_start = bus_wr && bus_sel;
        op.buf_load  = bus_wr && bus_sel && !bus_odd;
    end
endmodule

// File: rtl/serial_tx_status.sv
module serial_tx_status
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tx_op_t            op,
    input  logic [WORD_W-1:0] wdata,
    input  logic              char_sent,
    output tx_status_t        status,
    output logic              irq
);
    tx_status_t nxt;
    logic       irq_nxt;

    always_comb begin
        nxt     = status;
        irq_nxt = irq;
        if (op.status_wr) begin
            nxt.ie    = wdata[IE_B];
            nxt.maint = wdata[MAINT_B];
            nxt.brk   = wdata[BRK_B];
            if (!wdata[IE_B])
                irq_nxt = 1'b0;
            else if (status.done && !status.ie)
                irq_nxt = 1'b1;
        end
        if (op.buf_start) begin
            nxt.done = 1'b0;
            irq_nxt  = 1'b0;
        end else if (char_sent) begin
            nxt.done = 1'b1;
            irq_nxt  = nxt.ie;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= STATUS_RESET;
            irq    <= 1'b0;
        end else begin
            status <= nxt;
            irq    <= irq_nxt;
        end
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status.done && status.ie)); // R8
    AST_IE_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (op.status_wr && !wdata[IE_B]) |=> !irq); // R9
endmodule

// File: rtl/serial_tx_line.sv
module serial_tx_line
    import serial_tx_pkg::*;
#(
    parameter int DW = CHAR_W
)(
    input  logic          clk,
    input  logic          rst,
    input  tx_op_t        op,
    input  logic [DW-1:0] wbyte,
    input  logic          tx_ready,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    output logic          char_sent
);
    logic [DW-1:0] char_q;
    logic          pend_q;

    assign char_sent = pend_q && tx_ready;
    assign tx_valid  = pend_q;
    assign tx_data   = char_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            char_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (op.buf_load)
                char_q <= wbyte;
            if (op.buf_start)
                pend_q <= 1'b1;
            else if (char_sent)
                pend_q <= 1'b0;
        end
    end

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> tx_valid); // R6
    AST_DATA_STABLE_WAIT: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !op.buf_load) |=> $stable(tx_data)); // R6
endmodule

// File: rtl/serial_tx_regs.sv
module serial_tx_regs
    import serial_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic              bus_odd,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              tx_irq
);
    tx_op_t     op;
    tx_status_t status;
    logic       char_sent;

    serial_tx_decode u_dec (
        .bus_wr (bus_wr),
        .bus_sel(bus_sel),
        .bus_odd(bus_odd),
        .op     (op)
    );

    serial_tx_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wdata    (bus_wdata),
        .char_sent(char_sent),
        .status   (status),
        .irq      (tx_irq)
    );

    serial_tx_line #(.DW(CHAR_W)) u_line (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .wbyte    (bus_wdata[CHAR_W-1:0]),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .char_sent(char_sent)
    );

    always_comb begin
        if (bus_sel)
            bus_rdata = {{(WORD_W-CHAR_W){1'b0}}, tx_data};
        else
            bus_rdata = pack_status(status);
    end

    AST_DONE_EXCLUDES_VALID: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !status.done); // R6
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel) |=> (tx_valid && !status.done && !tx_irq)); // R5
    AST_SENT_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !(bus_wr && bus_sel)) |=> (status.done && !tx_valid)); // R7
    AST_ODD_STATUS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_sel && bus_odd && !tx_valid) |=> ($stable(status) && $stable(tx_irq))); // R3
    AST_COLLIDE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && bus_wr && bus_sel) |=> (tx_valid && !status.done)); // R10
endmodule

// File: tb/tb_serial_tx_regs.sv
`timescale 1ns/1ps
module tb_serial_tx_regs;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_odd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        tx_irq;

    int errors = 0;
    int checks = 0;
    int hs_count = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    serial_tx_regs dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_odd(bus_odd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_irq(tx_irq)
    );

    always @(posedge clk) if (!rst && tx_valid && tx_ready) hs_count <= hs_count + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic bus_write(input logic sel, input logic odd, input logic [15:0] d);
        bus_wr = 1'b1; bus_sel = sel; bus_odd = odd; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_odd = 1'b0; bus_wdata = '0;
    endtask

    task automatic read_reg(input logic sel, output logic [15:0] v);
        bus_sel = sel;
        #1 v = bus_rdata;
    endtask

    task automatic test_reset();
        logic [15:0] v;
        read_reg(1'b0, v); check("R1 status", v, 16'h0080);
        read_reg(1'b1, v); check("R1 buffer", v, 16'h0000);
        check("R1 valid", tx_valid, 0);
        check("R1 irq", tx_irq, 0);
    endtask

    task automatic test_status_write();
        logic [15:0] v;
        bus_write(1'b0, 1'b0, 16'hFFFF);
        read_reg(1'b0, v); check("R2 all ones", v, 16'h00C5);
        check("R9 ie set with done", tx_irq, 1);
        bus_write(1'b0, 1'b0, 16'h0004);
        read_reg(1'b0, v); check("R2 maint only", v, 16'h0084);
        check("R9 ie cleared", tx_irq, 0);
        bus_write(1'b0, 1'b0, 16'h0000);
        read_reg(1'b0, v); check("R2 cleared", v, 16'h0080);
    endtask

    task automatic test_odd_status();
        logic [15:0] v;
        bus_write(1'b0, 1'b1, 16'hFFFF);
        read_reg(1'b0, v); check("R3 odd status", v, 16'h0080);
        check("R3 irq", tx_irq, 0);
    endtask

    task automatic test_load_and_stall();
        logic [15:0] v;
        int base;
        tx_ready = 1'b0;
        base = hs_count;
        bus_write(1'b1, 1'b0, 16'h12A5);
        read_reg(1'b1, v); check("R4 buffer", v, 16'h00A5);
        check("R4 tx_data", tx_data, 8'hA5);
        check("R5 valid", tx_valid, 1);
        read_reg(1'b0, v); check("R5 done clear", v, 16'h0000);
        repeat (5) @(negedge clk);
        check("R6 valid held", tx_valid, 1);
        read_reg(1'b0, v); check("R6 done held clear", v, 16'h0000);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        check("R7 valid low", tx_valid, 0);
        read_reg(1'b0, v); check("R7 done set", v, 16'h0080);
        repeat (3) @(negedge clk);
        check("R7 one handshake", hs_count - base, 1);
    endtask

    task automatic test_odd_buffer();
        logic [15:0] v;
        bus_write(1'b1, 1'b1, 16'h3C77);
        read_reg(1'b1, v); check("R5 odd keeps byte", v, 16'h00A5);
        check("R5 odd valid", tx_valid, 1);
        read_reg(1'b0, v); check("R5 odd done clear", v, 16'h0000);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        read_reg(1'b0, v); check("R7 odd done", v, 16'h0080);
    endtask

    task automatic test_irq();
        logic [15:0] v;
        bus_write(1'b0, 1'b0, 16'h0040);
        check("R9 irq raised", tx_irq, 1);
        bus_write(1'b1, 1'b0, 16'h0033);
        check("R5 irq dropped", tx_irq, 0);
        repeat (2) @(negedge clk);
        check("R8 no irq while busy", tx_irq, 0);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        check("R8 irq on done", tx_irq, 1);
        read_reg(1'b0, v); check("R8 status", v, 16'h00C0);
        bus_write(1'b0, 1'b0, 16'h0000);
        check("R9 irq dropped", tx_irq, 0);
    endtask

    task automatic test_collision();
        logic [15:0] v;
        int base;
        base = hs_count;
        tx_ready = 1'b0;
        bus_write(1'b1, 1'b0, 16'h0011);
        tx_ready = 1'b1;
        bus_write(1'b1, 1'b0, 16'h0022);
        check("R10 valid stays", tx_valid, 1);
        check("R10 new byte", tx_data, 8'h22);
        read_reg(1'b0, v); check("R10 done clear", v, 16'h0000);
        @(negedge clk);
        tx_ready = 1'b0;
        check("R10 finished", tx_valid, 0);
        read_reg(1'b0, v); check("R10 done", v, 16'h0080);
        check("R10 handshakes", hs_count - base, 2);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_status_write();
        test_odd_status();
        test_load_and_stall();
        test_odd_buffer();
        test_irq();
        test_collision();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule